// File: doc/BRIEF.md
# Inbound Requester Domain Classifier

This block sits on the inbound side of a PCIe root port and sorts each arriving request (a memory read, a memory write or an error message) by the device that sent it. The sender is named by its 16-bit requester ID (bus, device, function). A local table maps that ID to an isolation domain number. Every later filtering decision is made per domain.

A write that lands in one of two message-signalled interrupt windows is treated as an MSI. One window is fixed at the top of the 32-bit space and the other is set by a parameter at a high 64-bit base. The block folds the MSI address and data into one of 2048 interrupt numbers. It then allows the interrupt only when the domain stored in that interrupt's descriptor matches the requester's domain. Any other read or write is DMA, and one high address bit picks which of the domain's two DMA windows applies. Error messages need only the requester lookup.

Both tables are loaded through a simple write port. Each answer appears exactly one clock after the request.

Top module: `inbound_domain_classifier`

## Requirements
- R1: After reset `rsp_valid` is 0, and both tables hold no valid entries, so every requester misses until it is written.
- R2: `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid` = 1, and 0 one cycle after a cycle with `req_valid` = 0. All response fields describe that request.
- R3: A requester whose ID has no valid table entry gets `rsp_class` = 0 (unclassified), `rsp_allow` = 0 and `rsp_domain` = 0. A requester that hits gets the stored domain on `rsp_domain`.
- R4: A request of kind 2 (error message) from a hit requester gets `rsp_class` = 3 and `rsp_allow` = 1, with `rsp_window` = 0 and `rsp_irq` = 0, whatever its address.
- R5: A hit request of kind 0 or 3 (read), or of kind 1 (write) outside both MSI windows, gets `rsp_class` = 1 (DMA) and `rsp_allow` = 1. `rsp_window` equals address bit 59 and `rsp_irq` = 0.
- R6: The low MSI window is every address with bits 63:32 all zero and bits 31:16 all one. Only writes (kind 1) there are MSIs, and a read of the same address is DMA.
- R7: The high MSI window is every address whose bits 63:16 equal bits 63:16 of `MSI_HI_BASE` (default 0x0000_1000_0000_0000). An address one window-span above it is DMA.
- R8: For an MSI, `rsp_irq` = (address bits 14:4 + data bits 10:0) modulo 2048.
- R9: An MSI gets `rsp_class` = 2. `rsp_allow` = 1 only if descriptor `rsp_irq` is valid and its domain equals the requester's domain; otherwise `rsp_allow` = 0.
- R10: A write with `cfg_target` = 0 stores {`cfg_valid`, `cfg_domain`} for requester ID `cfg_addr`. A write with `cfg_target` = 1 stores it in descriptor `cfg_addr[10:0]`. Writing `cfg_valid` = 0 removes the entry.
- R11: With hashed indexing, the requester table slot is ID bits 5:0 XOR ID bits 11:6. A write for an ID that shares a slot replaces the earlier ID, and the earlier ID then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_target | input | 1 | 0: requester table, 1: interrupt descriptor table |
| cfg_addr | input | 16 | Requester ID, or descriptor number in bits 10:0 |
| cfg_valid | input | 1 | Valid flag written to the entry |
| cfg_domain | input | 8 | Domain written to the entry |
| req_valid | input | 1 | Inbound request present |
| req_kind | input | 2 | 0 read, 1 write, 2 error message, 3 read |
| req_rid | input | 16 | Requester ID |
| req_addr | input | 64 | Request address |
| req_data | input | 32 | Write data (MSI payload) |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_class | output | 2 | 0 unclassified, 1 DMA, 2 MSI, 3 error message |
| rsp_domain | output | 8 | Requester's domain, 0 on a miss |
| rsp_window | output | 1 | DMA window select |
| rsp_irq | output | 11 | Interrupt number for an MSI |
| rsp_allow | output | 1 | Request is authorized |

## Verification
The bench builds the block with its defaults. These are hashed indexing into a 64-slot requester table, the full 11-bit interrupt range and a 64 KB span for each MSI window. The small table lets two real requester IDs share a slot, which is how the replacement rule is reached. The full interrupt range lets an address-plus-data sum wrap past 2047. Window edges are probed one bit outside each window, with the same requester used for both domain-match and domain-mismatch descriptors.

// File: rtl/idc_pkg.sv
package idc_pkg;
   typedef enum logic [1:0] {
      KIND_READ   = 2'd0,
      KIND_WRITE  = 2'd1,
      KIND_ERRMSG = 2'd2,
      KIND_READ2  = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_DMA  = 2'd1,
      CLS_MSI  = 2'd2,
      CLS_ERR  = 2'd3
   } req_class_e;
endpackage

// File: rtl/idc_rid_table.sv
module idc_rid_table #(
   parameter int RID_W = 16,
   parameter int DOM_W = 8,
   parameter int IDX_W = 6,
   parameter bit HASH  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RID_W-1:0] wr_rid,
   input  logic             wr_valid,
   input  logic [DOM_W-1:0] wr_dom,
   input  logic             rd_en,
   input  logic [RID_W-1:0] rd_rid,
   output logic             hit_o,
   output logic [DOM_W-1:0] dom_o
);
   localparam int DEPTH = 1 << IDX_W;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 12) else $error("IDX_W out of range");
      assert (!HASH || 2 * IDX_W <= RID_W) else $error("hash needs 2*IDX_W <= RID_W");
   end

   logic [IDX_W-1:0] wr_idx, rd_idx;

   generate
      if (HASH) begin : g_hash
         assign wr_idx = wr_rid[IDX_W-1:0] ^ wr_rid[2*IDX_W-1:IDX_W];
         assign rd_idx = rd_rid[IDX_W-1:0] ^ rd_rid[2*IDX_W-1:IDX_W];
      end else begin : g_direct
         assign wr_idx = wr_rid[IDX_W-1:0];
         assign rd_idx = rd_rid[IDX_W-1:0];
      end
   endgenerate

   logic [RID_W-1:0] tag_q [DEPTH];
   logic [DOM_W-1:0] dom_q [DEPTH];
   logic [DEPTH-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_rid;
         dom_q[wr_idx] <= wr_dom;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= wr_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o <= 1'b0;
         dom_o <= '0;
      end else if (rd_en) begin
         hit_o <= vld_q[rd_idx] && (tag_q[rd_idx] == rd_rid);
         dom_o <= dom_q[rd_idx];
      end
   end

   // R10: an entry removed in one cycle misses on a lookup in the next
   p_removed_misses_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(wr_en && !wr_valid) && rd_rid == $past(wr_rid)) |=> !hit_o);

   // R11: the most recent write to a slot is the one a lookup sees
   p_latest_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && $past(wr_en && wr_valid) && rd_rid == $past(wr_rid))
      |=> (hit_o && dom_o == $past(wr_dom, 2)));
endmodule

// File: rtl/idc_msi_decode.sv
module idc_msi_decode #(
   parameter int          ADDR_W      = 64,
   parameter int          DATA_W      = 32,
   parameter int          INT_W       = 11,
   parameter int          IRQ_LSB     = 4,
   parameter int          LO_SPAN_W   = 16,
   parameter int          HI_SPAN_W   = 16,
   parameter logic [63:0] MSI_HI_BASE = 64'h0000_1000_0000_0000
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              lo_hit_o,
   output logic              hi_hit_o,
   output logic [INT_W-1:0]  irq_o
);
   initial begin
      assert (ADDR_W == 64) else $error("ADDR_W must be 64");
      assert (IRQ_LSB >= 1) else $error("IRQ_LSB must be at least 1");
      assert (IRQ_LSB + INT_W <= LO_SPAN_W && IRQ_LSB + INT_W <= HI_SPAN_W)
         else $error("interrupt field must sit inside both windows");
      assert (LO_SPAN_W < 32 && HI_SPAN_W < ADDR_W) else $error("window span too wide");
      assert (DATA_W > INT_W) else $error("DATA_W must exceed INT_W");
   end

   assign lo_hit_o = (addr_i[ADDR_W-1:32] == '0) && (&addr_i[31:LO_SPAN_W]);
   assign hi_hit_o = (addr_i[ADDR_W-1:HI_SPAN_W] == MSI_HI_BASE[ADDR_W-1:HI_SPAN_W]);
   assign irq_o    = addr_i[IRQ_LSB +: INT_W] + data_i[INT_W-1:0];

   logic unused_bits;
   assign unused_bits = ^{addr_i[IRQ_LSB-1:0], data_i[DATA_W-1:INT_W]};
endmodule

// File: rtl/idc_irq_auth.sv
module idc_irq_auth #(
   parameter int INT_W = 11,
   parameter int DOM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [INT_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [DOM_W-1:0] wr_dom,
   input  logic             rd_en,
   input  logic [INT_W-1:0] rd_idx,
   output logic             desc_valid_o,
   output logic [DOM_W-1:0] desc_dom_o
);
   localparam int NUM_IRQ = 1 << INT_W;

   initial begin
      assert (INT_W >= 1 && INT_W <= 12) else $error("INT_W out of range");
   end

   logic [DOM_W-1:0]   dom_q [NUM_IRQ];
   logic [NUM_IRQ-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (wr_en) dom_q[wr_idx] <= wr_dom;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= wr_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc_valid_o <= 1'b0;
         desc_dom_o   <= '0;
      end else if (rd_en) begin
         desc_valid_o <= vld_q[rd_idx];
         desc_dom_o   <= dom_q[rd_idx];
      end
   end

   // R10: a descriptor read right after its write returns the written value
   p_desc_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && $past(wr_en) && rd_idx == $past(wr_idx))
      |=> (desc_valid_o == $past(wr_valid, 2)));
endmodule

// File: rtl/inbound_domain_classifier.sv
module inbound_domain_classifier
   import idc_pkg::*;
#(
   parameter int          RID_W       = 16,
   parameter int          DOM_W       = 8,
   parameter int          IDX_W       = 6,
   parameter bit          HASH        = 1'b1,
   parameter int          ADDR_W      = 64,
   parameter int          DATA_W      = 32,
   parameter int          INT_W       = 11,
   parameter int          IRQ_LSB     = 4,
   parameter int          LO_SPAN_W   = 16,
   parameter int          HI_SPAN_W   = 16,
   parameter logic [63:0] MSI_HI_BASE = 64'h0000_1000_0000_0000,
   parameter int          WIN_BIT     = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_target,
   input  logic [RID_W-1:0]  cfg_addr,
   input  logic              cfg_valid,
   input  logic [DOM_W-1:0]  cfg_domain,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [RID_W-1:0]  req_rid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              rsp_valid,
   output logic [1:0]        rsp_class,
   output logic [DOM_W-1:0]  rsp_domain,
   output logic              rsp_window,
   output logic [INT_W-1:0]  rsp_irq,
   output logic              rsp_allow
);
   initial begin
      assert (WIN_BIT < ADDR_W) else $error("WIN_BIT outside address");
      assert (INT_W <= RID_W) else $error("descriptor index wider than cfg_addr");
   end

   logic             lo_hit, hi_hit;
   logic [INT_W-1:0] dec_irq;

   idc_msi_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W), .IRQ_LSB(IRQ_LSB),
      .LO_SPAN_W(LO_SPAN_W), .HI_SPAN_W(HI_SPAN_W), .MSI_HI_BASE(MSI_HI_BASE)
   ) u_decode (
      .addr_i(req_addr), .data_i(req_data),
      .lo_hit_o(lo_hit), .hi_hit_o(hi_hit), .irq_o(dec_irq)
   );

   logic             rid_hit;
   logic [DOM_W-1:0] rid_dom;

   idc_rid_table #(
      .RID_W(RID_W), .DOM_W(DOM_W), .IDX_W(IDX_W), .HASH(HASH)
   ) u_rid_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && !cfg_target), .wr_rid(cfg_addr),
      .wr_valid(cfg_valid), .wr_dom(cfg_domain),
      .rd_en(req_valid), .rd_rid(req_rid),
      .hit_o(rid_hit), .dom_o(rid_dom)
   );

   logic             desc_valid;
   logic [DOM_W-1:0] desc_dom;

   idc_irq_auth #(
      .INT_W(INT_W), .DOM_W(DOM_W)
   ) u_irq_auth (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && cfg_target), .wr_idx(cfg_addr[INT_W-1:0]),
      .wr_valid(cfg_valid), .wr_dom(cfg_domain),
      .rd_en(req_valid), .rd_idx(dec_irq),
      .desc_valid_o(desc_valid), .desc_dom_o(desc_dom)
   );

   // request stage, aligned with the registered table reads
   logic             s_valid, s_err, s_msi, s_win;
   logic [INT_W-1:0] s_irq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_err   <= 1'b0;
         s_msi   <= 1'b0;
         s_win   <= 1'b0;
         s_irq   <= '0;
      end else begin
         s_valid <= req_valid;
         if (req_valid) begin
            s_err <= (req_kind == KIND_ERRMSG);
            s_msi <= (req_kind == KIND_WRITE) && (lo_hit || hi_hit);
            s_win <= req_addr[WIN_BIT];
            s_irq <= dec_irq;
         end
      end
   end

   req_class_e cls;

   always_comb begin
      if (!rid_hit)   cls = CLS_NONE;
      else if (s_err) cls = CLS_ERR;
      else if (s_msi) cls = CLS_MSI;
      else            cls = CLS_DMA;
   end

   assign rsp_valid  = s_valid;
   assign rsp_class  = cls;
   assign rsp_domain = rid_hit ? rid_dom : '0;
   assign rsp_window = (cls == CLS_DMA) ? s_win : 1'b0;
   assign rsp_irq    = (cls == CLS_MSI) ? s_irq : '0;

   always_comb begin
      case (cls)
         CLS_DMA, CLS_ERR: rsp_allow = s_valid;
         CLS_MSI:          rsp_allow = s_valid && desc_valid && (desc_dom == rid_dom);
         default:          rsp_allow = 1'b0;
      endcase
   end

   // R2: one response per request, one cycle later
   p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_rsp_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R3: a miss is never authorized and carries no domain
   p_miss_denied_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_class == CLS_NONE) |-> (!rsp_allow && rsp_domain == '0));

   // R4: an error message is classified as an error or as a miss, never else
   p_errmsg_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_ERRMSG)
      |=> (rsp_class == CLS_NONE || rsp_class == CLS_ERR));

   // R5: a DMA response carries the window bit of its request address
   p_window_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_class != CLS_DMA || rsp_window == $past(req_addr[WIN_BIT])));

   // R6: reads are never MSIs
   p_read_not_msi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == KIND_READ || req_kind == KIND_READ2))
      |=> rsp_class != CLS_MSI);
endmodule

// File: tb/inbound_domain_classifier_bench.sv
`timescale 1ns/1ps
module inbound_domain_classifier_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_target = 1'b0, cfg_valid = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [7:0]  cfg_domain = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_rid = '0;
   logic [63:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic        rsp_valid, rsp_window, rsp_allow;
   logic [1:0]  rsp_class;
   logic [7:0]  rsp_domain;
   logic [10:0] rsp_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   inbound_domain_classifier u_inbound_domain_classifier (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_target(cfg_target), .cfg_addr(cfg_addr),
      .cfg_valid(cfg_valid), .cfg_domain(cfg_domain),
      .req_valid(req_valid), .req_kind(req_kind), .req_rid(req_rid),
      .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_domain(rsp_domain),
      .rsp_window(rsp_window), .rsp_irq(rsp_irq), .rsp_allow(rsp_allow)
   );

   localparam logic [15:0] RID_A = 16'h0100;  // slot 4, domain 5
   localparam logic [15:0] RID_B = 16'h0208;  // slot 0, domain 9
   localparam logic [15:0] RID_C = 16'h0004;  // slot 4, collides with RID_A
   localparam logic [63:0] HI_BASE = 64'h0000_1000_0000_0000;

   task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic cfg_write(logic target, logic [15:0] addr, logic vld, logic [7:0] dom);
      @(negedge clk);
      cfg_we = 1'b1; cfg_target = target; cfg_addr = addr;
      cfg_valid = vld; cfg_domain = dom;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(logic [1:0] kind, logic [15:0] rid, logic [63:0] addr, logic [31:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_rid = rid;
      req_addr = addr; req_data = data;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_rsp(string req, logic [1:0] cls, logic [7:0] dom,
                             logic win, logic [10:0] irq, logic allow);
      check(req, "valid",  64'(rsp_valid),  64'(1'b1));
      check(req, "class",  64'(rsp_class),  64'(cls));
      check(req, "domain", 64'(rsp_domain), 64'(dom));
      check(req, "window", 64'(rsp_window), 64'(win));
      check(req, "irq",    64'(rsp_irq),    64'(irq));
      check(req, "allow",  64'(rsp_allow),  64'(allow));
   endtask

   task automatic t_reset_state;
      check("R1", "valid after reset", 64'(rsp_valid), 64'(1'b0));
      send(2'd0, RID_A, 64'h0, 32'h0);
      expect_rsp("R1", 2'd0, 8'd0, 1'b0, 11'd0, 1'b0);
   endtask

   task automatic t_program;
      cfg_write(1'b0, RID_A, 1'b1, 8'd5);
      cfg_write(1'b0, RID_B, 1'b1, 8'd9);
      cfg_write(1'b1, 16'd23, 1'b1, 8'd5);
      cfg_write(1'b1, 16'd2,  1'b1, 8'd9);
      cfg_write(1'b1, 16'd30, 1'b1, 8'd6);
      cfg_write(1'b1, 16'd40, 1'b0, 8'd5);
   endtask

   task automatic t_miss;
      send(2'd0, 16'h0333, 64'h1000, 32'h0);
      expect_rsp("R3", 2'd0, 8'd0, 1'b0, 11'd0, 1'b0);
   endtask

   task automatic t_dma;
      send(2'd0, RID_A, 64'h0000_0000_0040_0000, 32'h0);
      expect_rsp("R5", 2'd1, 8'd5, 1'b0, 11'd0, 1'b1);
      send(2'd0, RID_A, 64'h0800_0000_0040_0000, 32'h0);
      expect_rsp("R5", 2'd1, 8'd5, 1'b1, 11'd0, 1'b1);
      send(2'd1, RID_A, 64'h0000_0000_1234_5000, 32'h7);
      expect_rsp("R5", 2'd1, 8'd5, 1'b0, 11'd0, 1'b1);
      send(2'd3, RID_B, 64'h0800_0000_0000_0000, 32'h0);
      expect_rsp("R5", 2'd1, 8'd9, 1'b1, 11'd0, 1'b1);
   endtask

   task automatic t_msi_low;
      send(2'd0, RID_A, 64'h0000_0000_FFFF_0120, 32'd5);
      expect_rsp("R6", 2'd1, 8'd5, 1'b0, 11'd0, 1'b1);
      send(2'd1, RID_A, 64'h0000_0000_FFFF_0120, 32'd5);
      expect_rsp("R8", 2'd2, 8'd5, 1'b0, 11'd23, 1'b1);
      send(2'd1, RID_A, 64'h0000_0001_FFFF_0120, 32'd5);
      expect_rsp("R6", 2'd1, 8'd5, 1'b0, 11'd0, 1'b1);
      send(2'd1, RID_A, 64'h0000_0000_FFFE_0120, 32'd5);
      expect_rsp("R6", 2'd1, 8'd5, 1'b0, 11'd0, 1'b1);
   endtask

   task automatic t_msi_auth;
      send(2'd1, RID_A, 64'h0000_0000_FFFF_0100, 32'd14);
      expect_rsp("R9", 2'd2, 8'd5, 1'b0, 11'd30, 1'b0);
      send(2'd1, RID_A, 64'h0000_0000_FFFF_0100, 32'd24);
      expect_rsp("R9", 2'd2, 8'd5, 1'b0, 11'd40, 1'b0);
      send(2'd1, RID_B, 64'h0000_0000_FFFF_0120, 32'd5);
      expect_rsp("R9", 2'd2, 8'd9, 1'b0, 11'd23, 1'b0);
   endtask

   task automatic t_msi_high;
      send(2'd1, RID_B, HI_BASE | 64'h7FF0, 32'd3);
      expect_rsp("R7", 2'd2, 8'd9, 1'b0, 11'd2, 1'b1);
      send(2'd1, RID_B, HI_BASE | 64'h1_0000, 32'd3);
      expect_rsp("R7", 2'd1, 8'd9, 1'b0, 11'd0, 1'b1);
   endtask

   task automatic t_errmsg;
      send(2'd2, RID_B, 64'h0800_0000_FFFF_0120, 32'd5);
      expect_rsp("R4", 2'd3, 8'd9, 1'b0, 11'd0, 1'b1);
      send(2'd2, 16'h0777, 64'h0, 32'd0);
      expect_rsp("R4", 2'd0, 8'd0, 1'b0, 11'd0, 1'b0);
   endtask

   task automatic t_idle;
      @(negedge clk);
      check("R2", "valid when idle", 64'(rsp_valid), 64'(1'b0));
   endtask

   task automatic t_collision;
      cfg_write(1'b0, RID_C, 1'b1, 8'd7);
      send(2'd0, RID_A, 64'h0, 32'h0);
      expect_rsp("R11", 2'd0, 8'd0, 1'b0, 11'd0, 1'b0);
      send(2'd0, RID_C, 64'h0, 32'h0);
      expect_rsp("R11", 2'd1, 8'd7, 1'b0, 11'd0, 1'b1);
   endtask

   task automatic t_remove;
      cfg_write(1'b0, RID_B, 1'b0, 8'd9);
      send(2'd0, RID_B, 64'h0, 32'h0);
      expect_rsp("R10", 2'd0, 8'd0, 1'b0, 11'd0, 1'b0);
      cfg_write(1'b1, 16'd30, 1'b1, 8'd7);
      send(2'd1, RID_C, 64'h0000_0000_FFFF_0100, 32'd14);
      expect_rsp("R10", 2'd2, 8'd7, 1'b0, 11'd30, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_program();
      t_miss();
      t_dma();
      t_msi_low();
      t_msi_auth();
      t_msi_high();
      t_errmsg();
      t_idle();
      t_collision();
      t_remove();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule